// File: doc/BRIEF.md
# Two-Wire Register Slave with Wrapping Address Pointer

This block is the serial front end of a small configuration space: forty-eight 8-bit registers reached over a two-wire I2C bus. It watches the clock and data lines with a faster system clock and recognises START, repeated START and STOP conditions. When the 7-bit device address matches, it answers with an acknowledge. It pulls the data line low through an output-enable, and the pad ties the line to ground while that enable is high. Bytes go MSB first. An acknowledge is the data line held low during the ninth clock.

One register pointer serves both writes and reads. In a write transaction, the first byte after the device address sets the pointer. Each later byte is stored at the pointer, and the pointer then advances. A read sends the register at the pointer, advances it, and sends the next register for as long as the master acknowledges. The pointer wraps from the last register back to register zero, and it keeps its value across STOP. A bare read therefore continues where the last access left off. A random read is the write of an index, then a repeated START and a read address.

A DSP-mode input forbids the bare read form. In that mode a read address is refused unless an index was written earlier in the same transaction. The register contents exist only inside this block.

Top module: `i2c_regslave`

## Requirements
- R1: Only the device address 0x3A (parameter, 7 bits, followed by the R/W bit, 1 = read) is acknowledged. Any other address gets no acknowledge, and the bytes that follow it change no register until the next START.
- R2: In a write transaction, the first byte after the address loads the pointer. Each further byte is stored at the pointer and gets its own acknowledge.
- R3: The pointer advances by one after every data byte written or sent, and it goes from 0x2F to 0x00.
- R4: An index byte above 0x2F is still acknowledged, and it sets the pointer to 0x00.
- R5: A write of an index, then a repeated START and a read address, returns the register at that index first.
- R6: In a read, an acknowledge from the master (SDA low) brings the next register. A NACK ends the transfer with SDA released, and SDA stays released after STOP.
- R7: A read with no index phase starts at the pointer left by the last access, including across STOP. After an access to register n it returns register n+1.
- R8: With dsp_mode_i high, a read address not preceded by an index write in the same transaction gets no acknowledge, and SDA stays released until the next START. Random reads still work in this mode.
- R9: After reset every register holds 0x00, the pointer is 0x00 and SDA is released. The SDA enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dsp_mode_i | input | 1 | High: bare reads are refused |
| sda_oe_o | output | 1 | High: pull the data line low |

## Verification
The bench writes a burst that crosses from 0x2F into 0x00 and reads it back with acknowledges and a final NACK. A pointer that wraps at 0x3F or fails to wrap returns wrong bytes here. It sends an index above the top register, which would corrupt a stray location if the index were not folded. It runs bare reads after STOP, where a pointer cleared at STOP or one that misses the increment on the last byte returns the wrong register. It also sends a foreign address followed by data, which a loose address compare would store. A DSP-mode bare read must be refused and leave the bus floating high. A monitor counts SDA enable changes while SCL is high, the fault that would create false START or STOP conditions.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_RX,
        PH_RACK,
        PH_TX,
        PH_TACK,
        PH_HOLD
    } phase_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_rs_busev.sv
module i2c_rs_busev (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_s;

    prev_s prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // SDA moving while SCL stays high marks a bus condition
    assign start_o = prev_q.scl && scl_s && prev_q.sda && !sda_s;
    assign stop_o  = prev_q.scl && scl_s && !prev_q.sda && sda_s;
    assign rise_o  = !prev_q.scl && scl_s;
    assign fall_o  = prev_q.scl && !scl_s;
endmodule

// File: rtl/i2c_rs_regfile.sv
module i2c_rs_regfile #(
    parameter int NUM_REGS = 48,
    parameter int PTR_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [PTR_W-1:0]              addr_i,
    input  logic [i2c_rs_pkg::BYTE_W-1:0] wdata_i,
    output logic [i2c_rs_pkg::BYTE_W-1:0] rdata_o
);
    import i2c_rs_pkg::*;

    logic [BYTE_W-1:0] mem_d [NUM_REGS];
    logic [BYTE_W-1:0] mem_q [NUM_REGS];
    logic              in_range;

    assign in_range = (32'(addr_i) < NUM_REGS);

    always_comb begin
        mem_d = mem_q;
        if (we_i && in_range) mem_d[addr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = in_range ? mem_q[addr_i] : '0;
endmodule

// File: rtl/i2c_rs_ctrl.sv
module i2c_rs_ctrl #(
    parameter logic [6:0] DEV_ADDR = 7'h3A,
    parameter int         NUM_REGS = 48,
    parameter int         PTR_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sda_s,
    input  logic                          start_i,
    input  logic                          stop_i,
    input  logic                          rise_i,
    input  logic                          fall_i,
    input  logic                          dsp_mode_i,
    input  logic [i2c_rs_pkg::BYTE_W-1:0] rdata_i,
    output logic                          we_o,
    output logic [PTR_W-1:0]              ptr_o,
    output logic [i2c_rs_pkg::BYTE_W-1:0] wdata_o,
    output logic                          sda_oe_o
);
    import i2c_rs_pkg::*;

    localparam int LAST = NUM_REGS - 1;

    typedef struct packed {
        phase_e            ph;
        logic [2:0]        cnt;
        logic              full;
        logic [BYTE_W-1:0] sh;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
        logic              rw;
        logic              idx_pend;
        logic              idx_seen;
        logic              mack;
    } ctrl_s;

    ctrl_s            q, d;
    logic             we;
    logic [PTR_W-1:0] ptr_next;
    logic [PTR_W-1:0] idx_fold;
    logic             addr_ok;

    assign ptr_next = (32'(q.ptr) == LAST) ? '0 : q.ptr + 1'b1;
    assign idx_fold = (32'(q.sh) > LAST) ? '0 : q.sh[PTR_W-1:0];
    assign addr_ok  = (q.sh[7:1] == DEV_ADDR) &&
                      !(q.sh[0] && dsp_mode_i && !q.idx_seen);

    always_comb begin
        d  = q;
        we = 1'b0;
        if (stop_i) begin
            d.ph       = PH_IDLE;
            d.oe       = 1'b0;
            d.idx_pend = 1'b0;
            d.idx_seen = 1'b0;
        end else if (start_i) begin
            d.ph   = PH_ADDR;
            d.cnt  = '0;
            d.full = 1'b0;
            d.oe   = 1'b0;
        end else begin
            unique case (q.ph)
                PH_ADDR, PH_RX: begin
                    if (rise_i) begin
                        d.sh   = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt  = q.cnt + 1'b1;
                        d.full = (q.cnt == 3'd7);
                    end else if (fall_i && q.full) begin
                        d.full = 1'b0;
                        if (q.ph == PH_ADDR) begin
                            if (addr_ok) begin
                                d.oe       = 1'b1;
                                d.rw       = q.sh[0];
                                d.idx_pend = !q.sh[0];
                                d.ph       = PH_AACK;
                            end else begin
                                d.ph = PH_HOLD;
                            end
                        end else begin
                            d.oe = 1'b1;
                            d.ph = PH_RACK;
                            if (q.idx_pend) begin
                                d.ptr      = idx_fold;
                                d.idx_pend = 1'b0;
                                d.idx_seen = 1'b1;
                            end else begin
                                we    = 1'b1;
                                d.ptr = ptr_next;
                            end
                        end
                    end
                end
                PH_AACK: begin
                    if (fall_i) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh = rdata_i;
                            d.oe = !rdata_i[BYTE_W-1];
                            d.ph = PH_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.ph = PH_RX;
                        end
                    end
                end
                PH_RACK: begin
                    if (fall_i) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.ph  = PH_RX;
                    end
                end
                PH_TX: begin
                    if (fall_i) begin
                        if (q.cnt == 3'd7) begin
                            d.oe  = 1'b0;
                            d.ptr = ptr_next;
                            d.ph  = PH_TACK;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = !q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_TACK: begin
                    if (rise_i) begin
                        d.mack = !sda_s;
                    end else if (fall_i) begin
                        if (q.mack) begin
                            d.sh  = rdata_i;
                            d.oe  = !rdata_i[BYTE_W-1];
                            d.cnt = '0;
                            d.ph  = PH_TX;
                        end else begin
                            d.ph = PH_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, default: '0};
        else        q <= d;
    end

    assign we_o     = we;
    assign ptr_o    = q.ptr;
    assign wdata_o  = q.sh;
    assign sda_oe_o = q.oe;
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
    parameter logic [6:0] DEV_ADDR    = 7'h3A,
    parameter int         NUM_REGS    = 48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic dsp_mode_i,
    output logic sda_oe_o
);
    import i2c_rs_pkg::*;

    localparam int PTR_W = $clog2(NUM_REGS);

    logic              scl_s, sda_s;
    logic              start_ev, stop_ev, rise_ev, fall_ev;
    logic              wr_en;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] wdata, rdata;

    i2c_rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  ({scl_s, sda_s})
    );

    i2c_rs_busev u_busev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (start_ev),
        .stop_o  (stop_ev),
        .rise_o  (rise_ev),
        .fall_o  (fall_ev)
    );

    i2c_rs_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .rise_i     (rise_ev),
        .fall_i     (fall_ev),
        .dsp_mode_i (dsp_mode_i),
        .rdata_i    (rdata),
        .we_o       (wr_en),
        .ptr_o      (ptr),
        .wdata_o    (wdata),
        .sda_oe_o   (sda_oe_o)
    );

    i2c_rs_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .addr_i  (ptr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );
endmodule

// File: rtl/i2c_rs_checker.sv
module i2c_rs_checker #(
    parameter int NUM_REGS = 48,
    parameter int PTR_W    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             start_ev,
    input logic             stop_ev,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [PTR_W-1:0] ptr
);
    localparam int LAST = NUM_REGS - 1;

    assert_oe_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    assert_stop_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    assert_start_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);

    assert_ptr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) <= LAST);

    assert_write_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == ((32'($past(ptr)) == LAST) ? '0 : PTR_W'($past(ptr) + 1'b1))));
endmodule

bind i2c_regslave i2c_rs_checker #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe_o),
    .wr_en    (wr_en),
    .ptr      (ptr)
);

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam logic [6:0] DEV        = 7'h3A;
    localparam int         NREG       = 48;
    // {index, data}
    localparam logic [15:0] VEC [6] = '{16'h05A5, 16'h013C, 16'h2F81,
                                        16'h1742, 16'h2000, 16'h0AFF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic dsp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int fails = 0;
    int hi_moves = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;

    logic [7:0] shadow [NREG];
    int         sptr = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_regslave u_i2c_regslave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .dsp_mode_i (dsp),
        .sda_oe_o   (sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) hi_moves++;
        oe_prev = sda_oe;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic bit_cycle(input logic b, output logic s);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q();
        s = sda_bus; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            b[i] = s;
        end
        bit_cycle(!mack, s);
    endtask

    function automatic int adv(input int p);
        return (p == NREG - 1) ? 0 : p + 1;
    endfunction

    task automatic wr_index(input logic [7:0] idx, input string tag);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); check({tag, " addr ack"}, a, 1);
        send_byte(idx, a);         check({tag, " index ack"}, a, 1);
        sptr = (idx > NREG - 1) ? 0 : int'(idx);
    endtask

    task automatic wr_data(input logic [7:0] dat, input string tag);
        logic a;
        send_byte(dat, a); check({tag, " data ack"}, a, 1);
        shadow[sptr] = dat;
        sptr = adv(sptr);
    endtask

    task automatic rd_begin(input string tag);
        logic a;
        bus_start();
        send_byte({DEV, 1'b1}, a); check({tag, " read addr ack"}, a, 1);
    endtask

    task automatic rd_data(input logic mack, input string tag);
        logic [7:0] b;
        recv_byte(mack, b);
        check({tag, " read data"}, b, shadow[sptr]);
        sptr = adv(sptr);
    endtask

    initial begin
        logic       a;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) shadow[i] = '0;
        repeat (5) @(negedge clk);
        check("R9 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 oe after reset", sda_oe, 0);

        // R9/R7: bare read right after reset returns register 0 = 0x00
        rd_begin("R7 post-reset");
        rd_data(1'b0, "R9 reset value");
        bus_stop();

        // R2/R5: table of single-register writes with random read-back
        for (int v = 0; v < 6; v++) begin
            wr_index(VEC[v][15:8], "R2 vec");
            wr_data(VEC[v][7:0], "R2 vec");
            bus_stop();
            wr_index(VEC[v][15:8], "R5 vec");
            rd_begin("R5 vec");
            rd_data(1'b0, "R5 vec");
            bus_stop();
        end

        // R3: write burst crossing 0x2F -> 0x00
        wr_index(8'h2E, "R3 burst");
        wr_data(8'h11, "R3 burst");
        wr_data(8'h22, "R3 burst");
        wr_data(8'h33, "R3 wrap write");
        bus_stop();

        // R6/R3: random read with master ACKs across the wrap, then NACK
        wr_index(8'h2E, "R6 multi");
        rd_begin("R6 multi");
        rd_data(1'b1, "R6 first");
        rd_data(1'b1, "R6 second");
        rd_data(1'b0, "R3 wrapped read");
        bus_stop();
        repeat (4) @(negedge clk);
        check("R6 released after stop", sda_oe, 0);

        // R7: bare read continues at n+1 after the previous access
        rd_begin("R7 bare");
        rd_data(1'b1, "R7 bare first");
        rd_data(1'b0, "R7 bare second");
        bus_stop();

        // R4: index above top register folds to 0x00
        wr_index(8'h40, "R4 big index");
        wr_data(8'h77, "R4 big index");
        bus_stop();
        wr_index(8'h00, "R4 readback");
        rd_begin("R4 readback");
        rd_data(1'b0, "R4 reg0");
        bus_stop();

        // R1: foreign address ignored, its data stores nothing
        bus_start();
        send_byte({7'h3B, 1'b0}, a); check("R1 foreign addr nack", a, 0);
        send_byte(8'h03, a);         check("R1 foreign index nack", a, 0);
        send_byte(8'hEE, a);
        bus_stop();
        wr_index(8'h03, "R1 readback");
        rd_begin("R1 readback");
        rd_data(1'b0, "R1 reg3 unchanged");
        bus_stop();

        // R8: DSP mode refuses bare read, allows random read
        dsp = 1'b1;
        bus_start();
        send_byte({DEV, 1'b1}, a); check("R8 bare read refused", a, 0);
        recv_byte(1'b0, b);        check("R8 bus released", b, 8'hFF);
        bus_stop();
        wr_index(8'h05, "R8 random");
        rd_begin("R8 random");
        rd_data(1'b0, "R8 random data");
        bus_stop();
        dsp = 1'b0;

        check("R9 sda enable moved while scl high", hi_moves, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule